// File: doc/BRIEF.md
# Converter Host Bus Interface

This block sits between a microprocessor bus and the conversion sequencer of a sampling converter. The host drives four active-low strobes: chip select, write, read and calibrate. They reach the block with no timing relation to the converter clock. Each strobe passes through a two-flop synchroniser. The block then turns the synchronised strobes into single-cycle start and calibrate requests for the sequencer. With each start it passes an auto-zero select level, sampled at the moment the conversion starts.

When the sequencer reports a finished result, the block latches the result and pulls an active-low interrupt output low. It drives the 13-bit data bus through per-bit output enables. All bits are enabled during a host read. In a factory test combination, only a fixed subset of bits is enabled. A busy output shows whether a conversion or a calibration is in progress. A calibration runs to completion and cannot be cut short by further requests.

Top module: `cvt_host_if`

## Requirements
- R1: After reset, `int_n`=1, `busy`=0, `seq_start`=0, `seq_cal`=0 and `data_oe`=0.
- R2: A rising edge of `wr_n` while `cs_n`=0 and `cal_n`=1 produces a one-cycle pulse on `seq_start`, and `busy` goes to 1.
- R3: The level of `az_n` at the start is held on `seq_az_n` for the whole conversion.
- R4: A `seq_done` pulse during a conversion latches `seq_result` and drives `int_n` low. It also returns `busy` to 0.
- R5: With `cs_n`=0 and `rd_n`=0, `data_oe` is all ones and `data_out` carries the latched result, bit 12 being the sign. A read returns `int_n` to 1.
- R6: With no read and no test mode in effect, `data_oe`=0.
- R7: A write edge while `cal_n`=0 starts nothing.
- R8: A falling edge of `cal_n` while `cs_n`, `rd_n` and `wr_n` are all 1 produces a one-cycle pulse on `seq_cal`, and `busy` goes to 1.
- R9: While a calibration is in progress, further write edges and calibrate pulses are ignored. `busy` stays 1 until the sequencer drops its own busy line.
- R10: With `rd_n`=1, `cs_n`=0 and `cal_n`=0, only bits 2, 3, 5 and 6 are enabled (`data_oe`=13'h006C). Those bits carry the latched result.
- R11: Any new start or calibration returns `int_n` to 1 without a read.
- R12: A read during a conversion returns the previously latched result and leaves the sequencer untouched.
- R13: A write edge with `cs_n`=1 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host chip select, active low |
| wr_n | input | 1 | Host write strobe; its rising edge starts a conversion |
| rd_n | input | 1 | Host read strobe, active low |
| cal_n | input | 1 | Host calibrate strobe, active low |
| az_n | input | 1 | Auto-zero select level; 0 requests auto-zero |
| seq_start | output | 1 | One-cycle conversion request to the sequencer |
| seq_cal | output | 1 | One-cycle calibration request to the sequencer |
| seq_az_n | output | 1 | Auto-zero level captured at the last start |
| seq_busy | input | 1 | Sequencer is converting or calibrating |
| seq_done | input | 1 | One-cycle result-valid pulse from the sequencer |
| seq_result | input | 13 | Two's-complement result from the sequencer |
| int_n | output | 1 | Active-low interrupt: a result is waiting |
| busy | output | 1 | Conversion or calibration in progress |
| data_out | output | 13 | Data bus value, 0 on undriven bits |
| data_oe | output | 13 | Per-bit output enable for the data bus |

## Verification
The bench builds the block with its defaults: a 13-bit data word and two synchroniser stages. This fixes the request latency at three clock edges after a strobe edge, so each check can sample at a known cycle. The test-mode enable pattern applies to this word width. The bench's own sequencer model uses short conversion and calibration lengths. These bring the following cases within reach in a few hundred cycles: reads in the middle of a conversion, requests that land inside a running calibration, and an interrupt cleared by a restart.

// File: rtl/cvt_host_pkg.sv
package cvt_host_pkg;
    parameter int DATA_W = 13;
    parameter int SYNC_STAGES = 2;
    // Enable pattern in factory test mode: bits 2, 3, 5 and 6.
    parameter logic [DATA_W-1:0] TEST_OE_MASK = 13'h006C;

    typedef struct packed {
        logic              wr_prev;
        logic              cal_prev;
        logic              busy_prev;
        logic              start;
        logic              cal;
        logic              az_n;
        logic              conv_run;
        logic              cal_run;
        logic              int_act;
        logic [DATA_W-1:0] result;
        logic [DATA_W-1:0] oe;
    } host_state_t;
endpackage

// File: rtl/cvt_sync.sv
module cvt_sync #(
    parameter int          WIDTH   = 1,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= RST_VAL;
                end else if (g == 0) begin
                    stage_q[g] <= async_in;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/cvt_strobe_decode.sv
module cvt_strobe_decode (
    input  logic cs_s,
    input  logic wr_s,
    input  logic rd_s,
    input  logic cal_s,
    input  logic wr_prev,
    input  logic cal_prev,
    input  logic cal_run,
    output logic start_req,
    output logic cal_req,
    output logic read_act,
    output logic test_act
);
    logic wr_rise;
    logic cal_fall;

    always_comb begin
        wr_rise   = wr_s && !wr_prev;
        cal_fall  = !cal_s && cal_prev;
        // A running calibration cannot be interrupted by either request.
        start_req = wr_rise && !cs_s && cal_s && !cal_run;
        cal_req   = cal_fall && cs_s && rd_s && wr_s && !cal_run;
        read_act  = !cs_s && !rd_s;
        test_act  = !cs_s && rd_s && !cal_s;
    end
endmodule

// File: rtl/cvt_bus_drive.sv
module cvt_bus_drive #(
    parameter int                DATA_W  = 13,
    parameter logic [DATA_W-1:0] OE_MASK = '0
) (
    input  logic              read_act,
    input  logic              test_act,
    input  logic [DATA_W-1:0] result,
    input  logic [DATA_W-1:0] oe,
    output logic [DATA_W-1:0] oe_next,
    output logic [DATA_W-1:0] data_out
);
    genvar b;
    generate
        for (b = 0; b < DATA_W; b++) begin : g_bit
            assign oe_next[b]  = read_act || (test_act && OE_MASK[b]);
            assign data_out[b] = oe[b] & result[b];
        end
    endgenerate
endmodule

// File: rtl/cvt_host_if.sv
module cvt_host_if
    import cvt_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              cal_n,
    input  logic              az_n,
    output logic              seq_start,
    output logic              seq_cal,
    output logic              seq_az_n,
    input  logic              seq_busy,
    input  logic              seq_done,
    input  logic [DATA_W-1:0] seq_result,
    output logic              int_n,
    output logic              busy,
    output logic [DATA_W-1:0] data_out,
    output logic [DATA_W-1:0] data_oe
);
    localparam int NSTROBE = 5;

    logic [NSTROBE-1:0] strobe_s;
    logic cs_s, wr_s, rd_s, cal_s, az_s;
    logic start_req, cal_req, read_act, test_act;
    logic [DATA_W-1:0] oe_next;
    host_state_t s_d, s_q;

    cvt_sync #(.WIDTH(NSTROBE), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({az_n, cal_n, rd_n, wr_n, cs_n}),
        .sync_out (strobe_s)
    );

    assign {az_s, cal_s, rd_s, wr_s, cs_s} = strobe_s;

    cvt_strobe_decode u_dec (
        .cs_s      (cs_s),
        .wr_s      (wr_s),
        .rd_s      (rd_s),
        .cal_s     (cal_s),
        .wr_prev   (s_q.wr_prev),
        .cal_prev  (s_q.cal_prev),
        .cal_run   (s_q.cal_run),
        .start_req (start_req),
        .cal_req   (cal_req),
        .read_act  (read_act),
        .test_act  (test_act)
    );

    cvt_bus_drive #(.DATA_W(DATA_W), .OE_MASK(TEST_OE_MASK)) u_bus (
        .read_act (read_act),
        .test_act (test_act),
        .result   (s_q.result),
        .oe       (s_q.oe),
        .oe_next  (oe_next),
        .data_out (data_out)
    );

    always_comb begin
        s_d           = s_q;
        s_d.wr_prev   = wr_s;
        s_d.cal_prev  = cal_s;
        s_d.busy_prev = seq_busy;
        s_d.start     = start_req;
        s_d.cal       = cal_req;
        s_d.oe        = oe_next;

        if (start_req) begin
            s_d.az_n     = az_s;
            s_d.conv_run = 1'b1;
        end
        if (cal_req) begin
            s_d.cal_run  = 1'b1;
            s_d.conv_run = 1'b0;
        end
        if (s_q.cal_run && s_q.busy_prev && !seq_busy) begin
            s_d.cal_run = 1'b0;
        end
        if (seq_done && s_q.conv_run && !start_req) begin
            s_d.result   = seq_result;
            s_d.int_act  = 1'b1;
            s_d.conv_run = 1'b0;
        end
        // Clearing sources win over a result arriving in the same cycle.
        if (start_req || cal_req || read_act) begin
            s_d.int_act = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.wr_prev   <= 1'b1;
            s_q.cal_prev  <= 1'b1;
            s_q.az_n      <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign seq_start = s_q.start;
    assign seq_cal   = s_q.cal;
    assign seq_az_n  = s_q.az_n;
    assign int_n     = !s_q.int_act;
    assign busy      = s_q.conv_run || s_q.cal_run;
    assign data_oe   = s_q.oe;
endmodule

// File: rtl/cvt_host_if_chk.sv
module cvt_host_if_chk
    import cvt_host_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              seq_start,
    input logic              seq_cal,
    input logic              int_n,
    input logic              busy,
    input logic [DATA_W-1:0] data_oe
);
    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> !seq_start);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> busy);

    assert_cal_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_cal |-> busy && !seq_start);

    assert_cal_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_cal |=> !seq_cal);

    assert_int_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_start || seq_cal) |-> int_n);

    assert_oe_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe == '0) || (data_oe == '1) || (data_oe == TEST_OE_MASK));
endmodule

bind cvt_host_if cvt_host_if_chk u_chk (.*);

// File: tb/cvt_host_if_bench.sv
module cvt_host_if_bench;
    import cvt_host_pkg::*;

    localparam int CONV_LEN = 20;
    localparam int CAL_LEN  = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, cal_n = 1'b1, az_n = 1'b1;
    logic seq_start, seq_cal, seq_az_n, int_n, busy;
    logic seq_busy, seq_done;
    logic [DATA_W-1:0] seq_result, data_out, data_oe;
    logic [DATA_W-1:0] model_res = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int start_cnt, cal_cnt, seq_cnt;
    logic in_cal, az_seen;

    always #2.5 clk = ~clk;

    cvt_host_if u_cvt_host_if (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .cal_n(cal_n), .az_n(az_n), .seq_start(seq_start), .seq_cal(seq_cal),
        .seq_az_n(seq_az_n), .seq_busy(seq_busy), .seq_done(seq_done),
        .seq_result(seq_result), .int_n(int_n), .busy(busy),
        .data_out(data_out), .data_oe(data_oe)
    );

    assign seq_result = model_res;

    // Sequencer model: busy from the cycle after a request, done pulse at the end.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_busy <= 1'b0; seq_done <= 1'b0; start_cnt <= 0; cal_cnt <= 0;
            seq_cnt <= 0; in_cal <= 1'b0; az_seen <= 1'b1;
        end else begin
            seq_done <= 1'b0;
            if (seq_cal) begin
                cal_cnt <= cal_cnt + 1; seq_busy <= 1'b1; seq_cnt <= CAL_LEN; in_cal <= 1'b1;
            end else if (seq_start) begin
                start_cnt <= start_cnt + 1; seq_busy <= 1'b1; seq_cnt <= CONV_LEN;
                in_cal <= 1'b0; az_seen <= seq_az_n;
            end else if (seq_busy) begin
                if (seq_cnt == 0) begin
                    seq_busy <= 1'b0; seq_done <= !in_cal;
                end else begin
                    seq_cnt <= seq_cnt - 1;
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_wr();
        cs_n = 1'b0; cyc(1);
        wr_n = 1'b0; cyc(4);
        wr_n = 1'b1; cyc(5);
        cs_n = 1'b1; cyc(2);
    endtask

    task automatic pulse_cal();
        cal_n = 1'b0; cyc(4);
        cal_n = 1'b1; cyc(3);
    endtask

    task automatic do_read(output logic [DATA_W-1:0] oe, output logic [DATA_W-1:0] dat);
        cs_n = 1'b0; rd_n = 1'b0; cyc(5);
        oe = data_oe; dat = data_out;
        rd_n = 1'b1; cs_n = 1'b1; cyc(5);
    endtask

    // Each vector: {az_n level, sequencer result}
    localparam logic [DATA_W:0] VEC [4] = '{
        {1'b0, 13'h0FFF}, {1'b1, 13'h1000}, {1'b0, 13'h0000}, {1'b1, 13'h1ABC}
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        logic [DATA_W-1:0] oe, dat, prev;
        int sc;
        cyc(3);
        // R1 reset state
        check("R1 int_n", int_n, 1); check("R1 busy", busy, 0);
        check("R1 oe", data_oe, 0); check("R1 start", seq_start, 0);
        check("R1 cal", seq_cal, 0);
        rst_n = 1'b1; cyc(3);

        for (int i = 0; i < 4; i++) begin
            sc = start_cnt;
            model_res = VEC[i][DATA_W-1:0];
            az_n = VEC[i][DATA_W];
            pulse_wr();
            check("R2 start count", start_cnt, sc + 1);
            check("R2 busy", busy, 1);
            check("R3 az", az_seen, VEC[i][DATA_W]);
            cyc(CONV_LEN + 10);
            check("R3 az held", seq_az_n, VEC[i][DATA_W]);
            check("R4 int_n low", int_n, 0);
            check("R4 busy idle", busy, 0);
            do_read(oe, dat);
            check("R5 oe", oe, {DATA_W{1'b1}});
            check("R5 data", dat, VEC[i][DATA_W-1:0]);
            check("R5 int cleared", int_n, 1);
            check("R6 oe idle", data_oe, 0);
        end
        prev = VEC[3][DATA_W-1:0];

        // R13 no start without chip select
        sc = start_cnt;
        wr_n = 1'b0; cyc(4); wr_n = 1'b1; cyc(6);
        check("R13 no start", start_cnt, sc);
        check("R13 busy", busy, 0);

        // R10 test mode; R7 write ignored while calibrate low
        cs_n = 1'b0; cal_n = 1'b0; cyc(5);
        check("R10 oe mask", data_oe, 13'h006C);
        check("R10 data", data_out, prev & 13'h006C);
        sc = start_cnt;
        wr_n = 1'b0; cyc(4); wr_n = 1'b1; cyc(6);
        check("R7 no start", start_cnt, sc);
        check("R7 busy", busy, 0);
        cal_n = 1'b1; cyc(3); cs_n = 1'b1; cyc(5);
        check("R6 oe after test", data_oe, 0);

        // R12 read during conversion returns previous result
        model_res = 13'h0555;
        pulse_wr();
        sc = start_cnt;
        do_read(oe, dat);
        check("R12 old data", dat, prev);
        check("R12 no restart", start_cnt, sc);
        check("R12 busy", busy, 1);
        cyc(CONV_LEN + 10);
        check("R4 int after conv", int_n, 0);

        // R11 new start clears interrupt without a read
        model_res = 13'h0777;
        pulse_wr();
        check("R11 int by start", int_n, 1);
        cyc(CONV_LEN + 10);
        check("R4 int again", int_n, 0);

        // R8 calibration, R11 clear by cal, R9 requests ignored meanwhile
        sc = cal_cnt;
        pulse_cal();
        check("R8 cal count", cal_cnt, sc + 1);
        check("R8 busy", busy, 1);
        check("R11 int by cal", int_n, 1);
        sc = start_cnt;
        pulse_wr();
        check("R9 start ignored", start_cnt, sc);
        pulse_cal();
        check("R9 cal ignored", cal_cnt, 1);
        check("R9 busy held", busy, 1);
        cyc(CAL_LEN + 10);
        check("R9 busy released", busy, 0);
        check("R9 no result", int_n, 1);

        // R2 conversion works again after calibration
        model_res = 13'h1234;
        pulse_wr();
        cyc(CONV_LEN + 10);
        do_read(oe, dat);
        check("R2 post-cal data", dat, 13'h1234);

        finished = 1'b1;
        summary();
    end
endmodule